// File: doc/BRIEF.md
# Gated Coincidence Pattern Register

This block captures a sixteen-bit hit pattern. Every channel input is compared against one shared gate. When a channel is active while the gate is open, that channel's bit is set. The bit then stays set until a clear removes it. Each bit can only be set by a hit; a later quiet input never lowers it. A dataway inhibit shuts the gate for as long as it is held.

A host reaches the register through dataway commands. Each command is made of a station select, a sub-address and a function code, timed by two strobes. The host can read the pattern, read it and clear it, clear it alone, or force every bit to one as a self-test. The block answers each command with a Q bit and an X bit. A front-panel fast clear empties the register without any dataway cycle. Two multiplicity outputs count the set bits in channels 0 to 7 and in channels 8 to 15, for use in trigger decisions.

All inputs arrive already synchronised to `clk`. Register updates happen on the rising edge. Strobe-driven actions take effect at an edge where `s2` is high. The read bus, Q, X and the counts are combinational from the stored pattern and the command lines.

Top module: `coinc_pattern_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pattern clears to zero. With no command present, the read bus, `q`, `x` and both counts then read zero.
- R2: At a rising edge where `gate` is 1 and `inh` is 0, every channel with `chan_in[i]`=1 gets bit i set. The bit stays set at later edges until a clear happens.
- R3: While `inh` is 1, no bit is set from `chan_in`, whatever the value of `gate`.
- R4: A read is `sel`=1, `addr`=0 and `func`=0 (binary). A read drives the stored pattern onto `rd_data`, with `q`=1 and `x`=1.
- R5: A read-and-clear is `sel`=1, `addr`=0 and `func`=2. It drives the pattern onto `rd_data` with `q`=0 and `x`=1. The pattern is empty after an edge where `s2` is 1.
- R6: A clear is `sel`=1, `addr`=0 and `func`=9. It gives `q`=1 and `x`=1 and drives `rd_data` to zero. The clear takes effect only at an edge where `s2` is 1.
- R7: A test fill is `sel`=1, `addr`=0 and `func`=25. It gives `q`=1 and `x`=1. At an edge where `s2` is 1, it sets all 16 bits, whatever `gate` is.
- R8: `dw_z` or `dw_c`, together with `s2`=1 at an edge, clears the pattern. This clear does not need `sel`.
- R9: `fast_clr`=1 at an edge clears the pattern, with no strobe and no command.
- R10: When any clear meets a coincidence set or a test fill at the same edge, the clear wins and the pattern becomes zero.
- R11: Any other command gives `q`=0, `x`=0 and `rd_data`=0, and changes nothing. This covers `sel`=0, a non-zero `addr`, and any other function code.
- R12: `grp0_cnt` gives the number of set bits among bits 0 to 7. `grp1_cnt` gives the number among bits 8 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_in | input | 16 | Channel inputs |
| gate | input | 1 | Common coincidence gate |
| fast_clr | input | 1 | Front-panel fast clear |
| sel | input | 1 | Station select |
| addr | input | 4 | Sub-address |
| func | input | 5 | Function code |
| s1 | input | 1 | First strobe (read timing) |
| s2 | input | 1 | Second strobe (action timing) |
| dw_z | input | 1 | Dataway initialise |
| dw_c | input | 1 | Dataway clear |
| inh | input | 1 | Dataway inhibit |
| rd_data | output | 16 | Read bus, zero unless a read is decoded |
| q | output | 1 | Q response |
| x | output | 1 | Command-accepted response |
| grp0_cnt | output | 4 | Set-bit count, channels 0 to 7 |
| grp1_cnt | output | 4 | Set-bit count, channels 8 to 15 |

## Verification
The assertions assume the two strobes are never high in the same cycle, since a dataway cycle puts S1 before S2. The assertions also assume every input is already synchronous and holds steady between edges. The stimulus changes inputs only at the falling edge. Its randomised commands raise `s1` only in cycles where `s2` stays low. Directed sequences cover each clear source against simultaneous sets and fills.

// File: rtl/coinc_pkg.sv
// Shared constants for the coincidence pattern register.
// Assumes: function codes and the sub-address are plain binary values.
package coinc_pkg;
    localparam int unsigned FUNC_W = 5;
    localparam int unsigned ADDR_W = 4;
    localparam logic [FUNC_W-1:0] FN_READ     = 5'd0;
    localparam logic [FUNC_W-1:0] FN_READ_CLR = 5'd2;
    localparam logic [FUNC_W-1:0] FN_CLEAR    = 5'd9;
    localparam logic [FUNC_W-1:0] FN_FILL     = 5'd25;
endpackage

// File: rtl/coinc_cmd_decode.sv
// Decodes dataway commands into read enable, clear and fill requests and Q/X.
// Assumes: inputs are synchronous; s2 marks the action edge of a command.
module coinc_cmd_decode
    import coinc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FUNC_W-1:0] func,
    input  logic              s2,
    input  logic              dw_z,
    input  logic              dw_c,
    input  logic              fast_clr,
    output logic              rd_en,
    output logic              clr_req,
    output logic              fill_req,
    output logic              q,
    output logic              x
);
    logic hit;
    logic is_rd, is_rdc, is_clr, is_fill;

    // Station and sub-address qualify every command.
    always_comb begin
        hit     = sel && (addr == '0);
        is_rd   = hit && (func == FN_READ);
        is_rdc  = hit && (func == FN_READ_CLR);
        is_clr  = hit && (func == FN_CLEAR);
        is_fill = hit && (func == FN_FILL);
    end

    // Responses and action requests.
    always_comb begin
        rd_en    = is_rd || is_rdc;
        q        = is_rd || is_clr || is_fill;
        x        = is_rd || is_rdc || is_clr || is_fill;
        clr_req  = fast_clr || (s2 && (dw_z || dw_c || is_rdc || is_clr));
        fill_req = s2 && is_fill;
    end

    AST_Q_NEEDS_X: assert property (@(posedge clk) disable iff (!rst_n)
        q |-> x);                                              // R11
    AST_DW_CLEAR_ON_S2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !fast_clr) |-> s2);                        // R6
endmodule

// File: rtl/coinc_pattern_store.sv
// Holds the set-only channel pattern.
// Assumes: a clear beats a fill, and a fill beats a coincidence set.
module coinc_pattern_store #(
    parameter int unsigned CH_N = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] chan_in,
    input  logic            gate,
    input  logic            inh,
    input  logic            clr_req,
    input  logic            fill_req,
    output logic [CH_N-1:0] pattern
);
    logic [CH_N-1:0] hits;

    // A coincidence needs an open gate that is not inhibited.
    always_comb hits = (gate && !inh) ? chan_in : '0;

    // Pattern update with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) pattern <= '0;
        else if (fill_req)     pattern <= '1;
        else                   pattern <= pattern | hits;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (pattern == '0));                          // R10
    AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> ((pattern & $past(pattern)) == $past(pattern))); // R2
    AST_FILL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !clr_req) |=> (&pattern));                // R7
    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (inh && !fill_req && !clr_req) |=> $stable(pattern));  // R3
endmodule

// File: rtl/coinc_mult_count.sv
// Counts set bits per group of channels.
// Assumes: CH_N is a whole multiple of GRP_W.
module coinc_mult_count #(
    parameter int unsigned CH_N  = 16,
    parameter int unsigned GRP_W = 8,
    localparam int unsigned NGRP  = CH_N / GRP_W,
    localparam int unsigned CNT_W = $clog2(GRP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   pattern,
    output logic [NGRP*CNT_W-1:0] counts
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [CNT_W-1:0] sum;
        // Population count of one group.
        always_comb begin
            sum = '0;
            for (int i = 0; i < GRP_W; i++)
                sum = sum + CNT_W'(pattern[g*GRP_W + i]);
        end
        assign counts[g*CNT_W +: CNT_W] = sum;

        AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            sum <= CNT_W'(GRP_W));                             // R12
    end
endmodule

// File: rtl/coinc_pattern_reg.sv
// Top: a gated coincidence pattern register on a dataway with group multiplicity counts.
// Assumes: all inputs are synchronous to clk; s1 and s2 never overlap.
module coinc_pattern_reg
    import coinc_pkg::*;
#(
    parameter int unsigned CH_N  = 16,
    parameter int unsigned GRP_W = 8,
    localparam int unsigned CNT_W = $clog2(GRP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   chan_in,
    input  logic              gate,
    input  logic              fast_clr,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FUNC_W-1:0] func,
    input  logic              s1,
    input  logic              s2,
    input  logic              dw_z,
    input  logic              dw_c,
    input  logic              inh,
    output logic [CH_N-1:0]   rd_data,
    output logic              q,
    output logic              x,
    output logic [CNT_W-1:0]  grp0_cnt,
    output logic [CNT_W-1:0]  grp1_cnt
);
    localparam int unsigned NGRP = CH_N / GRP_W;

    logic            rd_en, clr_req, fill_req;
    logic [CH_N-1:0] pattern;
    logic [NGRP*CNT_W-1:0] counts;

    coinc_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .func(func),
        .s2(s2), .dw_z(dw_z), .dw_c(dw_c), .fast_clr(fast_clr),
        .rd_en(rd_en), .clr_req(clr_req), .fill_req(fill_req), .q(q), .x(x)
    );

    coinc_pattern_store #(.CH_N(CH_N)) u_store (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .gate(gate), .inh(inh),
        .clr_req(clr_req), .fill_req(fill_req), .pattern(pattern)
    );

    coinc_mult_count #(.CH_N(CH_N), .GRP_W(GRP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .pattern(pattern), .counts(counts)
    );

    // The read bus shows the pattern only while a read is decoded.
    always_comb rd_data = rd_en ? pattern : '0;

    // Group outputs.
    always_comb begin
        grp0_cnt = counts[0 +: CNT_W];
        grp1_cnt = counts[CNT_W +: CNT_W];
    end

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !x |-> (rd_data == '0));                               // R11
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(s1 && s2));                                          // R5
endmodule

// File: tb/coinc_pattern_reg_test.sv
module coinc_pattern_reg_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] chan_in = 0;
    logic        gate = 0, fast_clr = 0, sel = 0, s1 = 0, s2 = 0;
    logic        dw_z = 0, dw_c = 0, inh = 0;
    logic [3:0]  addr = 0;
    logic [4:0]  func = 0;
    logic [15:0] rd_data;
    logic        q, x;
    logic [3:0]  grp0_cnt, grp1_cnt;

    int vectors = 0, errors = 0;
    bit done = 0;
    string tag = "R1";
    logic [15:0] model = 0;

    always #4 clk = ~clk;

    coinc_pattern_reg uut (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .gate(gate),
        .fast_clr(fast_clr), .sel(sel), .addr(addr), .func(func), .s1(s1),
        .s2(s2), .dw_z(dw_z), .dw_c(dw_c), .inh(inh), .rd_data(rd_data),
        .q(q), .x(x), .grp0_cnt(grp0_cnt), .grp1_cnt(grp1_cnt)
    );

    function automatic int ones(input logic [7:0] v);
        int k = 0;
        for (int i = 0; i < 8; i++) if (v[i]) k++;
        return k;
    endfunction

    task automatic compare();
        logic ok_cmd;
        logic [15:0] e_rd;
        logic e_q, e_x;
        ok_cmd = sel && addr == 0;
        e_q = ok_cmd && (func == 0 || func == 9 || func == 25);
        e_x = ok_cmd && (func == 0 || func == 2 || func == 9 || func == 25);
        e_rd = (ok_cmd && (func == 0 || func == 2)) ? model : 16'h0;
        vectors++;
        if (rd_data !== e_rd || q !== e_q || x !== e_x ||
            grp0_cnt !== 4'(ones(model[7:0])) || grp1_cnt !== 4'(ones(model[15:8]))) begin
            errors++;
            $display("FAIL %s: rd=%h q=%b x=%b c0=%0d c1=%0d expected rd=%h q=%b x=%b c0=%0d c1=%0d",
                     tag, rd_data, q, x, grp0_cnt, grp1_cnt, e_rd, e_q, e_x,
                     ones(model[7:0]), ones(model[15:8]));
        end
    endtask

    // Advance the model by one edge, following the requirements.
    task automatic model_edge();
        logic hit, clr;
        hit = sel && addr == 0;
        clr = fast_clr || (s2 && (dw_z || dw_c || (hit && (func == 2 || func == 9))));
        if (!rst_n || clr) model = 0;
        else if (s2 && hit && func == 25) model = 16'hFFFF;
        else if (gate && !inh) model = model | chan_in;
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        chan_in = 0; gate = 0; fast_clr = 0; sel = 0; s1 = 0; s2 = 0;
        dw_z = 0; dw_c = 0; inh = 0; addr = 0; func = 0;
    endtask

    task automatic cmd(input logic [4:0] f, input logic strobe2);
        sel = 1; addr = 0; func = f; s2 = strobe2;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        chan_in = 16'hFFFF; gate = 1;
        repeat (3) step();
        idle(); rst_n = 1;
        step();

        tag = "R2";
        chan_in = 16'h0081; gate = 1; step();
        chan_in = 16'h0300; step();
        chan_in = 16'h0000; step();
        chan_in = 16'hF000; gate = 0; step();
        gate = 1; chan_in = 16'h0400; step();

        tag = "R4";
        idle(); cmd(0, 0); step(); step();

        tag = "R3";
        idle(); inh = 1; gate = 1; chan_in = 16'h0FF0; step();
        cmd(0, 0); step();

        tag = "R5";
        idle(); cmd(2, 0); s1 = 1; step();
        s1 = 0; s2 = 1; step();
        idle(); cmd(0, 0); step();

        tag = "R6";
        idle(); gate = 1; chan_in = 16'h5A5A; step();
        idle(); cmd(9, 0); step();
        cmd(9, 1); step();
        idle(); cmd(0, 0); step();

        tag = "R7";
        idle(); cmd(25, 0); step();
        cmd(25, 1); gate = 0; step();
        idle(); cmd(0, 0); step();

        tag = "R8";
        idle(); dw_z = 1; step();
        s2 = 1; step();
        idle(); gate = 1; chan_in = 16'h00F0; step();
        idle(); dw_c = 1; s2 = 1; step();
        idle(); cmd(0, 0); step();

        tag = "R9";
        idle(); gate = 1; chan_in = 16'hFF00; step();
        idle(); fast_clr = 1; step();
        idle(); cmd(0, 0); step();

        tag = "R10";
        idle(); fast_clr = 1; gate = 1; chan_in = 16'hFFFF; step();
        idle(); cmd(25, 1); dw_c = 1; step();
        idle(); cmd(9, 1); gate = 1; chan_in = 16'h3333; step();
        idle(); cmd(0, 0); step();

        tag = "R11";
        idle(); gate = 1; chan_in = 16'h1234; step();
        idle(); sel = 0; func = 0; s2 = 1; step();
        idle(); sel = 1; addr = 1; func = 9; s2 = 1; step();
        idle(); sel = 1; func = 1; s2 = 1; step();
        idle(); sel = 1; func = 24; s2 = 1; step();
        idle(); sel = 0; func = 25; s2 = 1; step();
        idle(); cmd(0, 0); step();

        tag = "R12";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            idle();
            chan_in = r[15:0] & r[31:16];
            gate = r[16];
            inh = (r[20:18] == 0);
            fast_clr = (r[25:21] == 0);
            sel = r[26];
            addr = (r[27] ? 4'd0 : 4'(r[31:28]));
            case (r[30:28])
                3'd0: func = 0;
                3'd1: func = 2;
                3'd2: func = 9;
                3'd3: func = 25;
                3'd4: func = 5'(r[15:11]);
                default: func = 0;
            endcase
            s2 = (r[9:7] == 0);
            s1 = !s2 && r[5];
            dw_z = s2 && (r[14:12] == 0);
            dw_c = s2 && (r[4:2] == 0);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule